// File: doc/BRIEF.md
# Hamming Single-Error-Correcting Codec

This block protects a 7-bit data word with four check bits, which gives an 11-bit codeword. Its encoder path takes a data word and produces the codeword. Its decoder path takes a received codeword and returns the data. A single inverted bit at any position of the codeword is located and repaired. Both paths are independent. Each path registers its result once, so a transaction appears on the outputs one clock after its input valid.

The codeword positions are numbered from 1 to 11. The check bits sit at the positions that are powers of two. The data bits fill the remaining positions in ascending order. Because of this placement, the decoder's four recomputed checks, read as a binary number, give the position of the inverted bit directly. Values of that number that point past the end of the codeword cannot come from a single error, and the decoder flags them as uncorrectable.

The check-bit count comes from the data width. It is the smallest r for which 2^r is at least the data width plus r plus one. For 7 data bits this gives r = 4.

Top module: `ham_codec`

## Requirements
- R1: In `enc_code_o`, vector index i holds codeword position i+1. Data bits d0..d6 occupy positions 3, 5, 6, 7, 9, 10, 11 in that order, with d0 at position 3.
- R2: Check positions 1, 2, 4 and 8 are each set so that every group has an even count of ones. The group of check position k is all positions whose number has the bit of value k set: {1,3,5,7,9,11}, {2,3,6,7,10,11}, {4,5,6,7} and {8,9,10,11}.
- R3: `enc_valid_o` equals `enc_valid_i` of the previous cycle. `enc_code_o` is the encoding of the word presented one cycle earlier.
- R4: `dec_valid_o` equals `dec_valid_i` of the previous cycle. The decoded data and the status flags belong to the word presented one cycle earlier.
- R5: A received word whose syndrome is zero returns its data bits unchanged and raises `dec_noerr_o`. The syndrome is the XOR of the position numbers of all set bits.
- R6: A syndrome from 1 to 11 inverts the bit at that position before the data is extracted, and raises `dec_corr_o`. Any single-bit error in a valid codeword therefore returns the original data.
- R7: A syndrome from 12 to 15 raises `dec_uncorr_o`. In that case the data bits are taken from the received word without any change.
- R8: While `dec_valid_o` is high, exactly one status flag is high. While it is low, all three flags are low.
- R9: A synchronous active-high `rst` clears both output valids, all status flags and the output data registers at the next clock edge. Reset overrides a valid input in the same cycle.
- R10: In a cycle with its input valid low, a path keeps its data output register (`enc_code_o` or `dec_data_o`) unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| enc_valid_i | input | 1 | Encoder input valid |
| enc_data_i | input | 7 | Data word to encode |
| enc_valid_o | output | 1 | Encoder output valid |
| enc_code_o | output | 11 | Codeword, index i = position i+1 |
| dec_valid_i | input | 1 | Decoder input valid |
| dec_code_i | input | 11 | Received codeword |
| dec_valid_o | output | 1 | Decoder output valid |
| dec_data_o | output | 7 | Recovered data word |
| dec_noerr_o | output | 1 | Received word had a zero syndrome |
| dec_corr_o | output | 1 | One bit was inverted to repair the word |
| dec_uncorr_o | output | 1 | Syndrome points outside the codeword |

## Verification
The checker's properties assume that `rst` is high at the first clock edge. They also assume that the input buses carry known values whenever the matching valid is high, since the syndrome the checker computes from `dec_code_i` is only meaningful then. The bench meets both assumptions. It holds reset for several cycles at the start. It changes every input only on the falling clock edge, and only to fully defined words. After each transaction it drops the valid and drives an altered, still defined word, to show that the outputs hold. Every received word the bench sends is either an exact encoding or an encoding with one or two bits flipped. This reaches all three syndrome classes without ever sending undefined data.

// File: rtl/ham_pkg.sv
package ham_pkg;

    parameter int DATA_W = 7;

    // smallest r with 2^r >= m + r + 1
    function automatic int calc_par_w(input int m);
        int r;
        r = 0;
        while ((1 << r) < (m + r + 1)) r++;
        return r;
    endfunction

    parameter int PAR_W  = calc_par_w(DATA_W);
    parameter int CODE_W = DATA_W + PAR_W;

    typedef enum logic [1:0] {
        ST_CLEAN = 2'd0,
        ST_FIXED = 2'd1,
        ST_BAD   = 2'd2
    } dec_status_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        dec_status_e       status;
    } dec_result_t;

    function automatic bit is_pow2(input int p);
        return (p > 0) && ((p & (p - 1)) == 0);
    endfunction

    // codeword positions checked by the parity bit at position p (a power of two)
    function automatic logic [CODE_W-1:0] group_mask(input int p);
        logic [CODE_W-1:0] m;
        m = '0;
        for (int q = 1; q <= CODE_W; q++)
            if ((q & p) != 0) m[q-1] = 1'b1;
        return m;
    endfunction

    // codeword position (1-based) carrying data bit i
    function automatic int data_pos(input int i);
        int cnt;
        int found;
        cnt   = 0;
        found = 0;
        for (int p = 1; p <= CODE_W; p++) begin
            if (!is_pow2(p)) begin
                if (cnt == i) found = p;
                cnt++;
            end
        end
        return found;
    endfunction

    // data bit index held at non-parity position p
    function automatic int data_index(input int p);
        int cnt;
        cnt = 0;
        for (int q = 1; q < p; q++)
            if (!is_pow2(q)) cnt++;
        return cnt;
    endfunction

endpackage

// File: rtl/ham_enc_core.sv
module ham_enc_core
    import ham_pkg::*;
(
    input  logic [DATA_W-1:0] data_i,
    output logic [CODE_W-1:0] code_o
);

    logic [CODE_W-1:0] spread;

    for (genvar p = 1; p <= CODE_W; p++) begin : g_pos
        if (is_pow2(p)) begin : g_par
            assign spread[p-1] = 1'b0;
            assign code_o[p-1] = ^(spread & group_mask(p));
        end else begin : g_dat
            localparam int IDX = data_index(p);
            assign spread[p-1] = data_i[IDX];
            assign code_o[p-1] = data_i[IDX];
        end
    end

endmodule

// File: rtl/ham_syndrome.sv
module ham_syndrome
    import ham_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    output logic [PAR_W-1:0]  syn_o
);

    for (genvar k = 0; k < PAR_W; k++) begin : g_chk
        assign syn_o[k] = ^(code_i & group_mask(1 << k));
    end

endmodule

// File: rtl/ham_correct.sv
module ham_correct
    import ham_pkg::*;
(
    input  logic [CODE_W-1:0] code_i,
    input  logic [PAR_W-1:0]  syn_i,
    output dec_result_t       res_o
);

    localparam logic [CODE_W-1:0] ONE = CODE_W'(1);

    logic              in_range;
    logic [CODE_W-1:0] flip;
    logic [CODE_W-1:0] fixed;

    always_comb begin
        in_range = (syn_i != '0) && (int'(syn_i) <= CODE_W);
        flip     = in_range ? (ONE << (syn_i - PAR_W'(1))) : '0;
        fixed    = code_i ^ flip;
    end

    for (genvar i = 0; i < DATA_W; i++) begin : g_ext
        assign res_o.data[i] = fixed[data_pos(i)-1];
    end

    always_comb begin
        if (syn_i == '0)   res_o.status = ST_CLEAN;
        else if (in_range) res_o.status = ST_FIXED;
        else               res_o.status = ST_BAD;
    end

endmodule

// File: rtl/ham_codec.sv
module ham_codec
    import ham_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              enc_valid_i,
    input  logic [DATA_W-1:0] enc_data_i,
    output logic              enc_valid_o,
    output logic [CODE_W-1:0] enc_code_o,
    input  logic              dec_valid_i,
    input  logic [CODE_W-1:0] dec_code_i,
    output logic              dec_valid_o,
    output logic [DATA_W-1:0] dec_data_o,
    output logic              dec_noerr_o,
    output logic              dec_corr_o,
    output logic              dec_uncorr_o
);

    logic [CODE_W-1:0] enc_code_c;
    logic [PAR_W-1:0]  dec_syn_c;
    dec_result_t       dec_res_c;

    ham_enc_core i_enc (
        .data_i (enc_data_i),
        .code_o (enc_code_c)
    );

    ham_syndrome i_syn (
        .code_i (dec_code_i),
        .syn_o  (dec_syn_c)
    );

    ham_correct i_fix (
        .code_i (dec_code_i),
        .syn_i  (dec_syn_c),
        .res_o  (dec_res_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            enc_valid_o <= 1'b0;
            enc_code_o  <= '0;
        end else begin
            enc_valid_o <= enc_valid_i;
            if (enc_valid_i) enc_code_o <= enc_code_c;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_valid_o  <= 1'b0;
            dec_data_o   <= '0;
            dec_noerr_o  <= 1'b0;
            dec_corr_o   <= 1'b0;
            dec_uncorr_o <= 1'b0;
        end else begin
            dec_valid_o  <= dec_valid_i;
            if (dec_valid_i) dec_data_o <= dec_res_c.data;
            dec_noerr_o  <= dec_valid_i && (dec_res_c.status == ST_CLEAN);
            dec_corr_o   <= dec_valid_i && (dec_res_c.status == ST_FIXED);
            dec_uncorr_o <= dec_valid_i && (dec_res_c.status == ST_BAD);
        end
    end

endmodule

// File: rtl/ham_codec_chk.sv
module ham_codec_chk
    import ham_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              enc_valid_i,
    input logic              enc_valid_o,
    input logic [CODE_W-1:0] enc_code_o,
    input logic              dec_valid_i,
    input logic [CODE_W-1:0] dec_code_i,
    input logic              dec_valid_o,
    input logic [DATA_W-1:0] dec_data_o,
    input logic              dec_noerr_o,
    input logic              dec_corr_o,
    input logic              dec_uncorr_o
);

    // syndrome of the received word, as the XOR of set-bit position numbers
    logic [PAR_W-1:0] in_syn;
    always_comb begin
        in_syn = '0;
        for (int p = 1; p <= CODE_W; p++)
            if (dec_code_i[p-1]) in_syn = in_syn ^ PAR_W'(p);
    end

    logic [2:0] flags;
    assign flags = {dec_noerr_o, dec_corr_o, dec_uncorr_o};

    // R2
    for (genvar k = 0; k < PAR_W; k++) begin : g_grp
        enc_group_even_chk: assert property (@(posedge clk) disable iff (rst)
            enc_valid_o |-> (^(enc_code_o & group_mask(1 << k)) == 1'b0));
    end

    // R3
    enc_valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        enc_valid_i |=> enc_valid_o);

    // R3
    enc_valid_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !enc_valid_i |=> !enc_valid_o);

    // R4
    dec_valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        dec_valid_i |=> dec_valid_o);

    // R4
    dec_valid_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !dec_valid_i |=> !dec_valid_o);

    // R5
    dec_clean_chk: assert property (@(posedge clk) disable iff (rst)
        (dec_valid_i && in_syn == '0) |=> dec_noerr_o);

    // R6
    dec_fixed_chk: assert property (@(posedge clk) disable iff (rst)
        (dec_valid_i && in_syn != '0 && int'(in_syn) <= CODE_W) |=> dec_corr_o);

    // R7
    dec_bad_chk: assert property (@(posedge clk) disable iff (rst)
        (dec_valid_i && int'(in_syn) > CODE_W) |=> dec_uncorr_o);

    // R8
    dec_one_flag_chk: assert property (@(posedge clk) disable iff (rst)
        dec_valid_o |-> $onehot(flags));

    // R8
    dec_no_flag_chk: assert property (@(posedge clk) disable iff (rst)
        !dec_valid_o |-> (flags == 3'b000));

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!enc_valid_o && !dec_valid_o && flags == 3'b000));

    // R10
    enc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !enc_valid_i |=> $stable(enc_code_o));

    // R10
    dec_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !dec_valid_i |=> $stable(dec_data_o));

endmodule

bind ham_codec ham_codec_chk i_ham_codec_chk (
    .clk          (clk),
    .rst          (rst),
    .enc_valid_i  (enc_valid_i),
    .enc_valid_o  (enc_valid_o),
    .enc_code_o   (enc_code_o),
    .dec_valid_i  (dec_valid_i),
    .dec_code_i   (dec_code_i),
    .dec_valid_o  (dec_valid_o),
    .dec_data_o   (dec_data_o),
    .dec_noerr_o  (dec_noerr_o),
    .dec_corr_o   (dec_corr_o),
    .dec_uncorr_o (dec_uncorr_o)
);

// File: tb/test_ham_codec.sv
module test_ham_codec;
    import ham_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              enc_valid_i = 1'b0;
    logic [DATA_W-1:0] enc_data_i = '0;
    logic              enc_valid_o;
    logic [CODE_W-1:0] enc_code_o;
    logic              dec_valid_i = 1'b0;
    logic [CODE_W-1:0] dec_code_i = '0;
    logic              dec_valid_o;
    logic [DATA_W-1:0] dec_data_o;
    logic              dec_noerr_o;
    logic              dec_corr_o;
    logic              dec_uncorr_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    ham_codec i_ham_codec (
        .clk          (clk),
        .rst          (rst),
        .enc_valid_i  (enc_valid_i),
        .enc_data_i   (enc_data_i),
        .enc_valid_o  (enc_valid_o),
        .enc_code_o   (enc_code_o),
        .dec_valid_i  (dec_valid_i),
        .dec_code_i   (dec_code_i),
        .dec_valid_o  (dec_valid_o),
        .dec_data_o   (dec_data_o),
        .dec_noerr_o  (dec_noerr_o),
        .dec_corr_o   (dec_corr_o),
        .dec_uncorr_o (dec_uncorr_o)
    );

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit tb_pow2(input int p);
        return (p & (p - 1)) == 0;
    endfunction

    // expected encoding: place data, then set check bits so the XOR of set positions is zero
    function automatic logic [CODE_W-1:0] model_encode(input logic [DATA_W-1:0] d);
        logic [CODE_W-1:0] w;
        int idx;
        int x;
        w   = '0;
        idx = 0;
        x   = 0;
        for (int p = 1; p <= CODE_W; p++) begin
            if (!tb_pow2(p)) begin
                w[p-1] = d[idx];
                if (d[idx]) x = x ^ p;
                idx++;
            end
        end
        for (int k = 0; k < PAR_W; k++) w[(1 << k) - 1] = x[k];
        return w;
    endfunction

    function automatic int model_syn(input logic [CODE_W-1:0] w);
        int x;
        x = 0;
        for (int p = 1; p <= CODE_W; p++) if (w[p-1]) x = x ^ p;
        return x;
    endfunction

    function automatic logic [DATA_W-1:0] model_extract(input logic [CODE_W-1:0] w);
        logic [DATA_W-1:0] d;
        int idx;
        d   = '0;
        idx = 0;
        for (int p = 1; p <= CODE_W; p++) begin
            if (!tb_pow2(p)) begin
                d[idx] = w[p-1];
                idx++;
            end
        end
        return d;
    endfunction

    task automatic run_enc(input logic [DATA_W-1:0] d);
        logic [CODE_W-1:0] exp;
        exp = model_encode(d);
        @(negedge clk);
        enc_valid_i = 1'b1;
        enc_data_i  = d;
        @(negedge clk);
        enc_valid_i = 1'b0;
        enc_data_i  = ~d;
        check(enc_valid_o === 1'b1, "R3 enc valid", 32'(enc_valid_o), 1);
        check(enc_code_o === exp, "R1 R2 codeword", 32'(enc_code_o), 32'(exp));
        @(negedge clk);
        check(enc_valid_o === 1'b0 && enc_code_o === exp, "R10 enc hold",
              32'({enc_valid_o, enc_code_o}), 32'({1'b0, exp}));
    endtask

    task automatic run_dec(input logic [CODE_W-1:0] w, input string req);
        int s;
        logic [CODE_W-1:0] fw;
        logic [DATA_W-1:0] ed;
        logic [2:0] ef;
        s  = model_syn(w);
        fw = w;
        if (s == 0) ef = 3'b100;
        else if (s <= CODE_W) begin
            ef = 3'b010;
            fw[s-1] = ~fw[s-1];
        end else ef = 3'b001;
        ed = model_extract(fw);
        @(negedge clk);
        dec_valid_i = 1'b1;
        dec_code_i  = w;
        @(negedge clk);
        dec_valid_i = 1'b0;
        dec_code_i  = ~w;
        check(dec_valid_o === 1'b1, "R4 dec valid", 32'(dec_valid_o), 1);
        check({dec_noerr_o, dec_corr_o, dec_uncorr_o} === ef, {req, " R8 flags"},
              32'({dec_noerr_o, dec_corr_o, dec_uncorr_o}), 32'(ef));
        check(dec_data_o === ed, {req, " data"}, 32'(dec_data_o), 32'(ed));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired checks=%0d", checks);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [CODE_W-1:0] cw;
        repeat (3) @(negedge clk);
        // R9: state during reset
        check(enc_valid_o === 1'b0 && dec_valid_o === 1'b0, "R9 reset valids",
              32'({enc_valid_o, dec_valid_o}), 0);
        check({dec_noerr_o, dec_corr_o, dec_uncorr_o} === 3'b000 && enc_code_o === '0
              && dec_data_o === '0, "R9 reset data", 32'(enc_code_o), 0);
        rst = 1'b0;

        // R1 R2 R3 R10: every data word
        for (int d = 0; d < (1 << DATA_W); d++) run_enc(DATA_W'(d));

        // R5 R6: clean words and every single-bit error
        for (int d = 0; d < (1 << DATA_W); d++) begin
            cw = model_encode(DATA_W'(d));
            run_dec(cw, "R5 clean");
            check(dec_data_o === DATA_W'(d), "R5 roundtrip", 32'(dec_data_o), d);
            @(negedge clk);
            check(dec_valid_o === 1'b0 && dec_data_o === DATA_W'(d), "R10 dec hold",
                  32'({dec_valid_o, dec_data_o}), d);
            for (int p = 0; p < CODE_W; p++) begin
                run_dec(cw ^ (CODE_W'(1) << p), "R6 single");
                check(dec_data_o === DATA_W'(d) && dec_corr_o === 1'b1, "R6 repaired",
                      32'(dec_data_o), d);
            end
        end

        // R7 and R6 miscorrection: every pair of flipped bits
        for (int d = 0; d < (1 << DATA_W); d += 5) begin
            cw = model_encode(DATA_W'(d));
            for (int a = 0; a < CODE_W; a++)
                for (int b = a + 1; b < CODE_W; b++)
                    run_dec(cw ^ (CODE_W'(1) << a) ^ (CODE_W'(1) << b), "R7 R6 double");
        end

        // R9: reset overrides valid inputs in the same cycle
        @(negedge clk);
        enc_valid_i = 1'b1;
        enc_data_i  = 7'h55;
        dec_valid_i = 1'b1;
        dec_code_i  = 11'h7FF;
        rst = 1'b1;
        @(negedge clk);
        check(enc_valid_o === 1'b0 && dec_valid_o === 1'b0 &&
              {dec_noerr_o, dec_corr_o, dec_uncorr_o} === 3'b000, "R9 reset over valid",
              32'({enc_valid_o, dec_valid_o, dec_noerr_o, dec_corr_o, dec_uncorr_o}), 0);
        rst = 1'b0;
        enc_valid_i = 1'b0;
        dec_valid_i = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule